// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous, strobe-controlled DRAM out of power-up and then keeps its rows alive. Reset holds every strobe high. A programmable pause follows, and then a fixed number of RAS-only warm-up pulses. After the warm-up the block raises `ready_o`, and from that point it schedules refreshes on its own.

A free-running interval timer adds one refresh to a small backlog every 8 ms / 512 rows. That is 781 cycles at the default 50 MHz clock. While the backlog is non-empty and the sequencer is idle, the block asserts `req_o` to the bus arbiter. The arbiter answers with `grant_i`, and the block then drives a CAS-before-RAS refresh on the strobes. In that refresh both CAS strobes fall first and RAS follows. No address is driven and no data is transferred. Between refreshes, `bus_own_o` is low, and the data-path controller owns the strobes.

All delays are cycle counts. The block computes them from the clock frequency parameter and from the timing parameters, which are given in nanoseconds or microseconds. At the defaults the counts are:

- pause: 10000 cycles
- RAS low time: 3 cycles
- precharge (max of RAS and CAS precharge): 2 cycles
- CAS-to-RAS setup: 1 cycle

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and the power-up pause, `ras_n_o`, `lcas_n_o`, `ucas_n_o`, `we_n_o` and `oe_n_o` are high, and `ready_o` and `req_o` are low. `ras_n_o` first falls PAUSE_US*CLK_MHZ clock edges after reset is released (10000 at the defaults).
- R2: After the pause, exactly WARMUP_CYCLES (8) RAS-only pulses are issued, with both CAS strobes high. Each pulse has RAS low for the RAS-low count (3 cycles) and high for at least the precharge count (2 cycles). `ready_o` rises after the last pulse.
- R3: The refresh interval is (REF_WINDOW_US*CLK_MHZ)/REF_ROWS cycles (781). With an empty backlog, `req_o` rises exactly one interval after `ready_o` rises.
- R4: A granted refresh drives both CAS strobes low while RAS is still high, for the setup count (1 cycle). RAS then falls with CAS still low and stays low for the RAS-low count (3 cycles). After that, all strobes are high for at least the precharge count before any further cycle.
- R5: `we_n_o` and `oe_n_o` stay high throughout a refresh. `bus_own_o` is high while the sequencer drives a refresh and low when it is idle after warm-up.
- R6: `grant_i` has no effect while `req_o` is low: the strobes stay high and the refresh count does not change.
- R7: Up to MAX_PENDING (4) refreshes may be postponed while no grant arrives. Holding the grant then serves them back to back, one refresh per pending entry, and `req_o` drops when the backlog is empty.
- R8: If an interval elapses while the backlog already holds MAX_PENDING entries, `overflow_o` is set and stays set until reset. It stays low as long as the backlog never exceeds that limit.
- R9: Each refresh produces a one-cycle `done_o` pulse in the first precharge cycle. `refresh_count_o` increments by one in the following cycle.
- R10: `req_o` is high only while `ready_o` is high, the sequencer is idle and the backlog is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Arbiter grant for a pending refresh |
| req_o | output | 1 | Refresh request to the arbiter |
| bus_own_o | output | 1 | Sequencer is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| oe_n_o | output | 1 | Output enable, active low, held high |
| ready_o | output | 1 | Warm-up complete, normal access allowed |
| done_o | output | 1 | One-cycle pulse per completed refresh |
| overflow_o | output | 1 | Sticky backlog overflow flag |
| refresh_count_o | output | CNT_W | Count of completed refreshes |

## Verification
The embedded properties check the following on every cycle:

- CAS is low before every RAS fall it accompanies.
- Every RAS low and every RAS high phase lasts at least its minimum count.
- `ready_o` and `overflow_o` are sticky.
- `done_o` lasts one cycle and advances the counter by one.
- `req_o` is never raised before warm-up.
- Overflow follows a tick into a full backlog.

Other behaviours need the directed scenarios:

- the exact pause length and warm-up pulse count
- the request interval
- the back-to-back draining of a backlog
- that a grant without a request is ignored

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_WU_LO,
    ST_WU_HI,
    ST_IDLE,
    ST_CAS_SU,
    ST_RAS_LO,
    ST_PRECH
  } seq_state_e;

  // round up to whole cycles, never below one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int unsigned PERIOD = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(PERIOD - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int unsigned MAX_PENDING = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic pending_o,
  output logic overflow_o
);
  localparam int unsigned PW = $clog2(MAX_PENDING + 1);

  logic [PW-1:0] pend_q;
  logic          full;

  assign full      = (pend_q == PW'(MAX_PENDING));
  assign pending_o = (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      overflow_o <= 1'b0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10: if (full) overflow_o <= 1'b1;
               else      pend_q     <= pend_q + 1'b1;
        2'b01: pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R7
  take_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pending_o);
  // R8
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !take_i && full) |=> overflow_o);
  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
  import dram_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 10000,
  parameter int unsigned WARMUP    = 8,
  parameter int unsigned RAS_CYC   = 3,
  parameter int unsigned PRE_CYC   = 2,
  parameter int unsigned CSR_CYC   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic ready_o,
  output logic idle_o,
  output logic done_o
);
  localparam int unsigned MAXC = (PAUSE_CYC > RAS_CYC) ?
      ((PAUSE_CYC > PRE_CYC) ? PAUSE_CYC : PRE_CYC) :
      ((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC);
  localparam int unsigned TW = $clog2(MAXC + 1);
  localparam int unsigned WW = (WARMUP > 1) ? $clog2(WARMUP) : 1;

  seq_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic [WW-1:0] wu_q;
  logic          tmr_zero;

  assign tmr_zero = (tmr_q == '0);
  assign ras_n_o  = !(state_q inside {ST_WU_LO, ST_RAS_LO});
  assign cas_n_o  = !(state_q inside {ST_CAS_SU, ST_RAS_LO});
  assign idle_o   = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      tmr_q   <= TW'(PAUSE_CYC - 1);
      wu_q    <= '0;
      ready_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!tmr_zero) tmr_q <= tmr_q - 1'b1;
      unique case (state_q)
        ST_PAUSE: if (tmr_zero) begin
          state_q <= ST_WU_LO;
          tmr_q   <= TW'(RAS_CYC - 1);
        end
        ST_WU_LO: if (tmr_zero) begin
          state_q <= ST_WU_HI;
          tmr_q   <= TW'(PRE_CYC - 1);
        end
        ST_WU_HI: if (tmr_zero) begin
          if (wu_q == WW'(WARMUP - 1)) begin
            state_q <= ST_IDLE;
            ready_o <= 1'b1;
          end else begin
            state_q <= ST_WU_LO;
            tmr_q   <= TW'(RAS_CYC - 1);
            wu_q    <= wu_q + 1'b1;
          end
        end
        ST_IDLE: if (start_i) begin
          state_q <= ST_CAS_SU;
          tmr_q   <= TW'(CSR_CYC - 1);
        end
        ST_CAS_SU: if (tmr_zero) begin
          state_q <= ST_RAS_LO;
          tmr_q   <= TW'(RAS_CYC - 1);
        end
        ST_RAS_LO: if (tmr_zero) begin
          state_q <= ST_PRECH;
          tmr_q   <= TW'(PRE_CYC - 1);
          done_o  <= 1'b1;
        end
        ST_PRECH: if (tmr_zero) state_q <= ST_IDLE;
        default: state_q <= ST_PAUSE;
      endcase
    end
  end

  // run-length monitors for the strobe timing checks
  logic [TW-1:0] lo_run_q, hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= '0;
    end else begin
      lo_run_q <= ras_n_o ? '0 : lo_run_q + 1'b1;
      hi_run_q <= !ras_n_o ? '0 : ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1);
    end
  end

  // R4
  cas_before_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
  // R2
  ras_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_run_q >= TW'(RAS_CYC)));
  // R2
  ras_high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_run_q >= TW'(PRE_CYC)));
  // R2
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 50,
  parameter int unsigned PAUSE_US      = 200,
  parameter int unsigned REF_WINDOW_US = 8000,
  parameter int unsigned REF_ROWS      = 512,
  parameter int unsigned WARMUP_CYCLES = 8,
  parameter int unsigned T_RAS_NS      = 60,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned T_CP_NS       = 10,
  parameter int unsigned T_CSR_NS      = 10,
  parameter int unsigned MAX_PENDING   = 4,
  parameter int unsigned CNT_W         = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  output logic             req_o,
  output logic             bus_own_o,
  output logic             ras_n_o,
  output logic             lcas_n_o,
  output logic             ucas_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             overflow_o,
  output logic [CNT_W-1:0] refresh_count_o
);
  localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int unsigned INT_CYC   = (REF_WINDOW_US * CLK_MHZ) / REF_ROWS;
  localparam int unsigned RAS_CYC   = ns2cyc(T_RAS_NS, CLK_MHZ);
  localparam int unsigned RP_CYC    = ns2cyc(T_RP_NS, CLK_MHZ);
  localparam int unsigned CP_CYC    = ns2cyc(T_CP_NS, CLK_MHZ);
  localparam int unsigned PRE_CYC   = (RP_CYC > CP_CYC) ? RP_CYC : CP_CYC;
  localparam int unsigned CSR_CYC   = ns2cyc(T_CSR_NS, CLK_MHZ);

  logic tick, pending, idle, start, cas_n;

  assign req_o     = idle && pending;
  assign start     = req_o && grant_i;
  assign bus_own_o = !idle;
  assign lcas_n_o  = cas_n;
  assign ucas_n_o  = cas_n;
  assign we_n_o    = 1'b1;
  assign oe_n_o    = 1'b1;

  refresh_tick_gen #(.PERIOD(INT_CYC)) u_tick (
    .clk_i, .rst_ni, .en_i(ready_o), .tick_o(tick)
  );

  refresh_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
    .clk_i, .rst_ni, .tick_i(tick), .take_i(start),
    .pending_o(pending), .overflow_o
  );

  strobe_sequencer #(
    .PAUSE_CYC(PAUSE_CYC), .WARMUP(WARMUP_CYCLES), .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC), .CSR_CYC(CSR_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start), .ras_n_o, .cas_n_o(cas_n),
    .ready_o, .idle_o(idle), .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     refresh_count_o <= '0;
    else if (done_o) refresh_count_o <= refresh_count_o + 1'b1;
  end

  // R10
  req_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ready_o);
  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (refresh_count_o == $past(refresh_count_o) + 1'b1));
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int unsigned PAUSE_CYC = 10000;
  localparam int unsigned INT_CYC   = 781;
  localparam int unsigned RAS_CYC   = 3;
  localparam int unsigned PRE_CYC   = 2;
  localparam int unsigned WARMUP    = 8;
  localparam int unsigned MAXP      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grant = 1'b0;
  logic        req, bus_own, ras_n, lcas_n, ucas_n, we_n, oe_n, ready, done, ovf;
  logic [15:0] cnt;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dram_refresh_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant), .req_o(req), .bus_own_o(bus_own),
    .ras_n_o(ras_n), .lcas_n_o(lcas_n), .ucas_n_o(ucas_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .ready_o(ready), .done_o(done), .overflow_o(ovf), .refresh_count_o(cnt)
  );

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 2000 && !req; i++) step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1", "strobes high in reset", int'({ras_n, lcas_n, ucas_n, we_n, oe_n}), 31);
    chk("R1", "ready/req low in reset", int'({ready, req}), 0);
    chk("R9", "count zero in reset", int'(cnt), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_pause();
    int n = 0;
    bit bad = 0;
    while (n < 20000) begin
      step();
      n++;
      if (!ras_n) break;
      if (!lcas_n || !ucas_n || !we_n || !oe_n || ready || req) bad = 1;
    end
    chk("R1", "edges to first RAS fall", n, PAUSE_CYC);
    chk("R1", "quiet strobes during pause", int'(bad), 0);
  endtask

  task automatic t_warmup();
    int lo = 1, hi = 0, pulses = 1, minlo = 999, minhi = 999;
    bit prev = 0, badcas = 0, early = 0;
    for (int i = 0; i < 500; i++) begin
      step();
      if (!lcas_n || !ucas_n) badcas = 1;
      if (ready) break;
      if (req) early = 1;
      if (ras_n) begin
        if (!prev) begin minlo = (lo < minlo) ? lo : minlo; lo = 0; end
        hi++;
      end else begin
        if (prev) begin minhi = (hi < minhi) ? hi : minhi; hi = 0; pulses++; end
        lo++;
      end
      prev = ras_n;
    end
    chk("R2", "warm-up pulses", pulses, WARMUP);
    chk("R2", "warm-up RAS low width", minlo, RAS_CYC);
    chk("R2", "warm-up RAS high width", minhi, PRE_CYC);
    chk("R2", "CAS high in warm-up", int'(badcas), 0);
    chk("R2", "ready after warm-up", int'(ready), 1);
    chk("R10", "no request before ready", int'(early), 0);
  endtask

  task automatic t_interval();
    int n = 0;
    while (!req && n < 2000) begin step(); n++; end
    chk("R3", "cycles ready to first request", n, INT_CYC);
  endtask

  task automatic t_refresh();
    int c0 = int'(cnt);
    int lows = 0;
    bit badlo = 0;
    grant = 1'b1;
    step();
    grant = 1'b0;
    chk("R4", "CAS low before RAS", int'({lcas_n, ucas_n, ras_n}), 1);
    chk("R5", "bus owned in refresh", int'(bus_own), 1);
    for (int i = 0; i < RAS_CYC; i++) begin
      step();
      if (!ras_n) lows++;
      if (lcas_n || ucas_n || !we_n || !oe_n) badlo = 1;
    end
    chk("R4", "RAS low cycles", lows, RAS_CYC);
    chk("R5", "CAS low, WE/OE high during RAS low", int'(badlo), 0);
    step();
    chk("R4", "all strobes high in precharge", int'({ras_n, lcas_n, ucas_n}), 7);
    chk("R9", "done pulse", int'(done), 1);
    chk("R10", "request drops when backlog empty", int'(req), 0);
    step();
    chk("R9", "done one cycle", int'(done), 0);
    chk("R9", "count advanced", int'(cnt), c0 + 1);
    chk("R4", "precharge held", int'(ras_n && bus_own), 1);
    step();
    chk("R5", "bus released when idle", int'(bus_own), 0);
  endtask

  task automatic t_grant_ignored();
    int c0 = int'(cnt);
    bit bad = 0;
    grant = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!ras_n || !lcas_n || !ucas_n || bus_own) bad = 1;
    end
    grant = 1'b0;
    chk("R6", "strobes idle under stray grant", int'(bad), 0);
    chk("R6", "count unchanged under stray grant", int'(cnt), c0);
  endtask

  task automatic run_drain(int cyc, output int dones);
    dones = 0;
    grant = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (done) dones++;
    end
    grant = 1'b0;
  endtask

  task automatic t_backlog();
    int c0, d;
    wait_req();
    repeat (2 * INT_CYC + 38) step();
    chk("R7", "request held while postponed", int'(req), 1);
    c0 = int'(cnt);
    run_drain(40, d);
    chk("R7", "back-to-back refreshes", d, 3);
    chk("R7", "count after drain", int'(cnt), c0 + 3);
    chk("R7", "request low after drain", int'(req), 0);
    chk("R8", "no overflow within limit", int'(ovf), 0);
  endtask

  task automatic t_overflow();
    int d;
    wait_req();
    repeat (MAXP * INT_CYC + 76) step();
    chk("R8", "overflow set", int'(ovf), 1);
    run_drain(50, d);
    chk("R8", "saturated backlog drained", d, MAXP);
    chk("R8", "overflow sticky", int'(ovf), 1);
  endtask

  initial begin
    t_reset();
    t_pause();
    t_warmup();
    t_interval();
    t_refresh();
    t_grant_ignored();
    t_backlog();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule